// File: doc/BRIEF.md
# Interrupt Vector Ring Producer

This block takes interrupt events from on-chip sources over a single valid/ready input and stores each event as a four-dword record in a circular buffer in host-visible memory. Memory is reached through a plain word-write port: one 32-bit write per cycle, with a 40-bit byte address. The block keeps the write pointer. The host programs the read pointer, drains records until the two pointers match, and then writes back its read pointer. While unread records remain and interrupts are enabled, a level-high host interrupt is asserted.

Both pointers count bytes. Each record is 16 bytes long, so the write pointer moves by 16 per record and wraps by masking with the ring length in bytes minus one. The ring length is programmed as the log2 of its size in dwords. If the ring fills while overflow handling is on, the newest record overwrites the oldest one and a sticky flag appears in bit 0 of the write-pointer register value. After an overflow, the host resumes reading at the write pointer plus 16. If writeback is on, every write-pointer update, overflow flag included, is also written to a separate programmed memory address.

Software reaches the block through a small register port. Offset 0 is control. Offset 1 holds address bits [39:8] of the ring base. Offset 2 is the read pointer and offset 3 the write pointer. Offsets 4 and 5 hold the low 32 and high 8 bits of the writeback address. The control word has these fields: bit 0 interrupt enable, bit 1 ring enable, bit 2 overflow enable, bit 3 writeback enable, bit 4 overflow clear (write 1, reads 0), bit 5 soft reset (level), bits [12:8] ring size log2 in dwords (clamped to 3..MAX_LOG2_DW), and bit 16 busy (read only).

Top module: `ivring_top`

## Requirements
- R1: After reset the write pointer reads 0, the overflow flag and busy are 0, ev_ready and host_irq are low, and no memory write occurs.
- R2: An accepted event produces four consecutive dword writes at {base,8'h00} + wptr + 0, 4, 8 and 12. The dwords are: dword0 = {24'h0, src}; dword1 = {4'h0, data}; dword2 = {asid[15:0], vm[7:0], ring[7:0]}; dword3 = 0.
- R3: After each record the write pointer becomes (wptr + 16) & ((1 << (size_log2 + 2)) - 1). Reading offset 3 returns {wptr[31:4], 3'b000, overflow_flag}.
- R4: An event is accepted only when the interrupt-enable and ring-enable control bits are both 1.
- R5: With overflow disabled, ev_ready stays low while the ring is full, meaning (wptr + 16) masked equals the masked read pointer.
- R6: With overflow enabled, a record arriving at a full ring is still written at the write pointer and sets the sticky flag (bit 0 of the write-pointer value). The flag stays set until control bit 4 is written as 1.
- R7: With writeback enabled, each record is followed by one extra memory write of the write-pointer register value to the 40-bit writeback address. With writeback disabled, a record costs exactly four writes.
- R8: host_irq is high exactly when interrupt enable is 1 and the masked write pointer differs from the masked read pointer.
- R9: Busy (control bit 16) reads 1 while a record is being written, and ev_ready is low during that time.
- R10: While the soft-reset bit is 1 the block returns to idle, a write in progress is abandoned, the write pointer and the overflow flag go to 0, and no event is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event offered by a source |
| ev_ready | output | 1 | Event accepted on this cycle's edge when valid |
| ev_src | input | 8 | Source identifier |
| ev_data | input | 28 | Source payload |
| ev_ring | input | 8 | Ring identifier |
| ev_vm | input | 8 | Virtual-machine identifier |
| ev_asid | input | 16 | Address-space identifier |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | 40 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| host_irq | output | 1 | Level interrupt while unread records exist |

## Verification
The record path is driven with a mixed field pattern and with an all-ones pattern. The mixed pattern shows whether each field lands in its own bit range. The all-ones pattern shows whether any field spills into the zero-filled upper bits or into the reserved dword. A run of five records in a four-slot ring, with the host draining after each, separates correct wrap masking from plain pointer growth. A two-slot ring is filled first with overflow off, which must stall the input, and then with overflow and writeback on, which must overwrite, raise the sticky flag and mirror it to memory. A soft reset asserted in the middle of a record shows that the write is cut short and the pointer is cleared.

// File: rtl/ivring_pkg.sv
package ivring_pkg;

  localparam int unsigned VEC_BYTES = 16;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_BASE = 3'd1;
  localparam logic [2:0] RA_RPTR = 3'd2;
  localparam logic [2:0] RA_WPTR = 3'd3;
  localparam logic [2:0] RA_WBLO = 3'd4;
  localparam logic [2:0] RA_WBHI = 3'd5;

  typedef enum logic [2:0] {
    W_IDLE, W_D0, W_D1, W_D2, W_D3, W_WB
  } wr_state_t;

  typedef struct packed {
    logic [7:0]  src;
    logic [27:0] data;
    logic [7:0]  ring;
    logic [7:0]  vm;
    logic [15:0] asid;
  } ivec_t;

  typedef struct packed {
    logic       irq_en;
    logic       ring_en;
    logic       ovf_en;
    logic       wb_en;
    logic       soft_rst;
    logic [4:0] size_log2;
  } ctrl_t;

  // Byte mask of the ring: length in dwords is 2**log2, clamped to a legal range.
  function automatic logic [31:0] ring_mask(input logic [4:0] log2_dw,
                                            input int unsigned max_log2);
    int unsigned l;
    l = {27'd0, log2_dw};
    if (l < 3) l = 3;
    if (l > max_log2) l = max_log2;
    return (32'd1 << (l + 2)) - 32'd1;
  endfunction

  function automatic logic [31:0] ptr_advance(input logic [31:0] p,
                                              input logic [31:0] m);
    return (p + VEC_BYTES) & m;
  endfunction

  function automatic logic [31:0] vec_dword(input ivec_t v, input logic [1:0] idx);
    case (idx)
      2'd0:    return {24'd0, v.src};
      2'd1:    return {4'd0, v.data};
      2'd2:    return {v.asid, v.vm, v.ring};
      default: return 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/ivring_regs.sv
module ivring_regs
  import ivring_pkg::*;
#(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [31:0]   wptr,
  input  logic          ovf,
  input  logic          busy,
  output ctrl_t         ctrl,
  output logic [31:0]   base,
  output logic [31:0]   rptr,
  output logic [39:0]   wb_addr,
  output logic          ovf_clr,
  output logic          wptr_ld,
  output logic [31:0]   wptr_ld_val
);

  logic wr_ctrl;
  assign wr_ctrl     = reg_we && (reg_addr == RA_CTRL);
  assign ovf_clr     = wr_ctrl && reg_wdata[4];
  assign wptr_ld     = reg_we && (reg_addr == RA_WPTR);
  assign wptr_ld_val = reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '{irq_en: 1'b0, ring_en: 1'b0, ovf_en: 1'b0, wb_en: 1'b0,
                   soft_rst: 1'b0, size_log2: 5'd3};
      base    <= '0;
      rptr    <= '0;
      wb_addr <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        RA_CTRL: ctrl <= '{irq_en: reg_wdata[0], ring_en: reg_wdata[1],
                           ovf_en: reg_wdata[2], wb_en: reg_wdata[3],
                           soft_rst: reg_wdata[5], size_log2: reg_wdata[12:8]};
        RA_BASE: base <= reg_wdata;
        RA_RPTR: rptr <= reg_wdata;
        RA_WBLO: wb_addr[31:0] <= reg_wdata;
        RA_WBHI: wb_addr[39:32] <= reg_wdata[7:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL: reg_rdata = {15'd0, busy, 3'd0, ctrl.size_log2, 2'd0,
                            ctrl.soft_rst, 1'b0, ctrl.wb_en, ctrl.ovf_en,
                            ctrl.ring_en, ctrl.irq_en};
      RA_BASE: reg_rdata = base;
      RA_RPTR: reg_rdata = rptr;
      RA_WPTR: reg_rdata = (wptr & ~32'hF) | {31'd0, ovf};
      RA_WBLO: reg_rdata = wb_addr[31:0];
      RA_WBHI: reg_rdata = {24'd0, wb_addr[39:32]};
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ivring_writer.sv
module ivring_writer
  import ivring_pkg::*;
#(
  parameter int unsigned MAW = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  ctrl_t          ctrl,
  input  logic [31:0]    mask,
  input  logic [31:0]    base,
  input  logic [31:0]    rptr,
  input  logic [39:0]    wb_addr,
  input  logic           ovf_clr,
  input  logic           wptr_ld,
  input  logic [31:0]    wptr_ld_val,
  input  logic           ev_valid,
  input  ivec_t          ev_vec,
  output logic           ev_ready,
  output logic [31:0]    wptr,
  output logic           ovf,
  output logic           busy,
  output logic           full,
  output logic           commit,
  output logic           mem_we,
  output logic [MAW-1:0] mem_addr,
  output logic [31:0]    mem_wdata
);

  wr_state_t   state;
  ivec_t       vec_q;
  logic [31:0] slot;
  logic [1:0]  idx;
  logic        accept;

  assign full     = ptr_advance(wptr, mask) == (rptr & mask);
  assign ev_ready = (state == W_IDLE) && ctrl.irq_en && ctrl.ring_en &&
                    !ctrl.soft_rst && (!full || ctrl.ovf_en);
  assign accept   = ev_valid && ev_ready;
  assign busy     = (state != W_IDLE);
  assign commit   = (state == W_D3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= W_IDLE;
      vec_q <= '0;
      slot  <= '0;
      wptr  <= '0;
      ovf   <= 1'b0;
    end else if (ctrl.soft_rst) begin
      state <= W_IDLE;
      wptr  <= '0;
      ovf   <= 1'b0;
    end else begin
      if (ovf_clr) ovf <= 1'b0;
      case (state)
        W_IDLE: begin
          if (wptr_ld) wptr <= wptr_ld_val & mask & ~32'hF;
          if (accept) begin
            vec_q <= ev_vec;
            slot  <= wptr & mask;
            if (full) ovf <= 1'b1;
            state <= W_D0;
          end
        end
        W_D0: state <= W_D1;
        W_D1: state <= W_D2;
        W_D2: state <= W_D3;
        W_D3: begin
          wptr  <= ptr_advance(slot, mask);
          state <= ctrl.wb_en ? W_WB : W_IDLE;
        end
        default: state <= W_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      W_D1:    idx = 2'd1;
      W_D2:    idx = 2'd2;
      W_D3:    idx = 2'd3;
      default: idx = 2'd0;
    endcase
  end

  always_comb begin
    mem_we    = (state != W_IDLE);
    mem_addr  = {base, 8'h00} + {8'h00, slot} + {36'd0, idx, 2'b00};
    mem_wdata = vec_dword(vec_q, idx);
    if (state == W_WB) begin
      mem_addr  = wb_addr;
      mem_wdata = (wptr & ~32'hF) | {31'd0, ovf};
    end
  end

endmodule

// File: rtl/ivring_top.sv
module ivring_top
  import ivring_pkg::*;
#(
  parameter int unsigned MAX_LOG2_DW = 14,
  parameter int unsigned RAW = 3,
  parameter int unsigned RDW = 32,
  parameter int unsigned MAW = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ev_valid,
  output logic           ev_ready,
  input  logic [7:0]     ev_src,
  input  logic [27:0]    ev_data,
  input  logic [7:0]     ev_ring,
  input  logic [7:0]     ev_vm,
  input  logic [15:0]    ev_asid,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [RDW-1:0] reg_wdata,
  output logic [RDW-1:0] reg_rdata,
  output logic           mem_we,
  output logic [MAW-1:0] mem_addr,
  output logic [31:0]    mem_wdata,
  output logic           host_irq
);

  ctrl_t       ctrl;
  logic [31:0] base, rptr, wptr, mask, wptr_ld_val;
  logic [39:0] wb_addr;
  logic        ovf, ovf_clr, wptr_ld, busy, full, commit;
  logic        irq_en, ring_en, ovf_en, soft_rst;
  ivec_t       ev_vec;

  assign ev_vec   = '{src: ev_src, data: ev_data, ring: ev_ring, vm: ev_vm, asid: ev_asid};
  assign mask     = ring_mask(ctrl.size_log2, MAX_LOG2_DW);
  assign irq_en   = ctrl.irq_en;
  assign ring_en  = ctrl.ring_en;
  assign ovf_en   = ctrl.ovf_en;
  assign soft_rst = ctrl.soft_rst;
  assign host_irq = irq_en && ((wptr & mask) != (rptr & mask));

  ivring_regs #(.AW(RAW), .DW(RDW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wptr(wptr), .ovf(ovf),
    .busy(busy), .ctrl(ctrl), .base(base), .rptr(rptr), .wb_addr(wb_addr),
    .ovf_clr(ovf_clr), .wptr_ld(wptr_ld), .wptr_ld_val(wptr_ld_val)
  );

  ivring_writer #(.MAW(MAW)) u_writer (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .mask(mask), .base(base),
    .rptr(rptr), .wb_addr(wb_addr), .ovf_clr(ovf_clr), .wptr_ld(wptr_ld),
    .wptr_ld_val(wptr_ld_val), .ev_valid(ev_valid), .ev_vec(ev_vec),
    .ev_ready(ev_ready), .wptr(wptr), .ovf(ovf), .busy(busy), .full(full),
    .commit(commit), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

endmodule

// File: rtl/ivring_checker.sv
module ivring_checker
  import ivring_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        ev_valid,
  input logic        ev_ready,
  input logic        irq_en,
  input logic        ring_en,
  input logic        ovf_en,
  input logic        soft_rst,
  input logic        full,
  input logic        commit,
  input logic        busy,
  input logic        mem_we,
  input logic        ovf,
  input logic        ovf_clr,
  input logic        host_irq,
  input logic [31:0] wptr,
  input logic [31:0] rptr,
  input logic [31:0] mask
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we);

  assert_wptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !soft_rst) |=> wptr == ptr_advance($past(wptr), $past(mask)));

  assert_accept_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready) |-> (irq_en && ring_en));

  assert_full_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !ovf_en) |-> !ev_ready);

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr && !soft_rst) |=> ovf);

  assert_irq_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en || (wptr == (rptr & mask))) |-> !host_irq);

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ev_ready);

  assert_soft_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!busy && wptr == 32'd0 && !ovf));

endmodule

bind ivring_top ivring_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .irq_en(irq_en), .ring_en(ring_en), .ovf_en(ovf_en), .soft_rst(soft_rst),
  .full(full), .commit(commit), .busy(busy), .mem_we(mem_we), .ovf(ovf),
  .ovf_clr(ovf_clr), .host_irq(host_irq), .wptr(wptr), .rptr(rptr), .mask(mask)
);

// File: tb/ivring_top_bench.sv
module ivring_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [39:0] RING_BASE = 40'h00_1234_5600;
  localparam logic [39:0] WB_ADDR   = 40'h55_0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [7:0]  ev_src = '0, ev_ring = '0, ev_vm = '0;
  logic [27:0] ev_data = '0;
  logic [15:0] ev_asid = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_we;
  logic [39:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        host_irq;

  int n_chk = 0, n_bad = 0, wr_count = 0, cycles = 0;
  logic [31:0] mem [logic [39:0]];

  ivring_top u_ivring_top (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_src(ev_src), .ev_data(ev_data), .ev_ring(ev_ring), .ev_vm(ev_vm),
    .ev_asid(ev_asid), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .host_irq(host_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (mem_we) begin
      mem[mem_addr] = mem_wdata;
      wr_count++;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cycles > 20000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: act=%0d cycles exp<=20000", cycles);
        summary();
        $finish;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_mem(input logic [39:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'hDEAD_BEEF;
  endfunction

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic offer(input logic [7:0] s, input logic [27:0] d,
                       input logic [7:0] r, input logic [7:0] v, input logic [15:0] a);
    int guard;
    guard = 0;
    ev_src = s; ev_data = d; ev_ring = r; ev_vm = v; ev_asid = a;
    ev_valid = 1'b1;
    while (!ev_ready && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic send(input logic [7:0] s, input logic [27:0] d,
                      input logic [7:0] r, input logic [7:0] v, input logic [15:0] a);
    offer(s, d, r, v, a);
    repeat (7) @(negedge clk);
  endtask

  // Bench's own idea of the control word layout.
  function automatic logic [31:0] cw(input bit ie, input bit re, input bit oe,
                                     input bit we, input bit clr, input bit sr,
                                     input int lg);
    return {19'd0, lg[4:0], 2'd0, sr, clr, we, oe, re, ie};
  endfunction

  task automatic ring_restart(input int lg);
    reg_write(3'd0, cw(0, 0, 0, 0, 1, 0, lg));
    reg_write(3'd3, 32'd0);
    reg_write(3'd2, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 ready", {63'd0, ev_ready}, 64'd0);
    chk("R1 irq", {63'd0, host_irq}, 64'd0);
    reg_read(3'd3, d); chk("R1 wptr", {32'd0, d}, 64'd0);
    reg_read(3'd0, d); chk("R1 busy", {63'd0, d[16]}, 64'd0);
    chk("R1 no writes", wr_count, 0);
  endtask

  task automatic t_gate();
    int c0;
    c0 = wr_count;
    reg_write(3'd0, cw(1, 0, 0, 0, 0, 0, 4));
    ev_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 ready irq-only", {63'd0, ev_ready}, 64'd0);
    reg_write(3'd0, cw(0, 1, 0, 0, 0, 0, 4));
    repeat (4) @(negedge clk);
    chk("R4 ready ring-only", {63'd0, ev_ready}, 64'd0);
    ev_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 no writes", wr_count - c0, 0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    int c0;
    reg_write(3'd1, RING_BASE[39:8]);
    reg_write(3'd0, cw(1, 1, 0, 0, 0, 0, 4));
    c0 = wr_count;
    offer(8'hA5, 28'hABCDEF1, 8'h3C, 8'h7E, 16'hBEEF);
    chk("R9 ready busy", {63'd0, ev_ready}, 64'd0);
    reg_read(3'd0, d); chk("R9 busy set", {63'd0, d[16]}, 64'd1);
    repeat (7) @(negedge clk);
    reg_read(3'd0, d); chk("R9 busy clear", {63'd0, d[16]}, 64'd0);
    chk("R2 d0", rd_mem(RING_BASE + 0),  32'h0000_00A5);
    chk("R2 d1", rd_mem(RING_BASE + 4),  32'h0ABC_DEF1);
    chk("R2 d2", rd_mem(RING_BASE + 8),  32'hBEEF_7E3C);
    chk("R2 d3", rd_mem(RING_BASE + 12), 32'h0);
    chk("R7 four writes no wb", wr_count - c0, 4);
    reg_read(3'd3, d); chk("R3 wptr 16", {32'd0, d}, 64'h10);
    chk("R8 irq pending", {63'd0, host_irq}, 64'd1);
    reg_write(3'd2, 32'h10);
    chk("R8 irq drained", {63'd0, host_irq}, 64'd0);
    send(8'hFF, 28'hFFF_FFFF, 8'hFF, 8'hFF, 16'hFFFF);
    chk("R2 ones d0", rd_mem(RING_BASE + 16), 32'h0000_00FF);
    chk("R2 ones d1", rd_mem(RING_BASE + 20), 32'h0FFF_FFFF);
    chk("R2 ones d2", rd_mem(RING_BASE + 24), 32'hFFFF_FFFF);
    chk("R2 ones d3", rd_mem(RING_BASE + 28), 32'h0);
    reg_write(3'd0, cw(0, 1, 0, 0, 0, 0, 4));
    chk("R8 irq disabled", {63'd0, host_irq}, 64'd0);
  endtask

  task automatic t_wrap();
    logic [31:0] d, exp;
    ring_restart(4);
    reg_write(3'd0, cw(1, 1, 0, 0, 0, 0, 4));
    for (int k = 0; k < 5; k++) begin
      send(8'(8'h40 + k), 28'(k), 8'd1, 8'd2, 16'd3);
      exp = ((k + 1) * 16) & 32'h3F;
      reg_read(3'd3, d); chk("R3 wrap wptr", {32'd0, d}, {32'd0, exp});
      reg_write(3'd2, exp);
    end
    chk("R3 wrapped slot", rd_mem(RING_BASE + 0), 32'h44);
    chk("R3 slot 48", rd_mem(RING_BASE + 48), 32'h43);
  endtask

  task automatic t_full();
    logic [31:0] d;
    int c0;
    ring_restart(3);
    reg_write(3'd0, cw(1, 1, 0, 0, 0, 0, 3));
    send(8'h11, 28'd0, 8'd0, 8'd0, 16'd0);
    c0 = wr_count;
    ev_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 stalled", {63'd0, ev_ready}, 64'd0);
    ev_valid = 1'b0;
    @(negedge clk);
    chk("R5 nothing written", wr_count - c0, 0);
    reg_write(3'd4, WB_ADDR[31:0]);
    reg_write(3'd5, {24'd0, WB_ADDR[39:32]});
    reg_write(3'd0, cw(1, 1, 1, 1, 0, 0, 3));
    c0 = wr_count;
    send(8'h77, 28'd5, 8'd0, 8'd0, 16'd0);
    chk("R6 overwrite slot", rd_mem(RING_BASE + 16), 32'h77);
    reg_read(3'd3, d); chk("R6 flag set", {32'd0, d}, 64'h1);
    chk("R7 wb value", rd_mem(WB_ADDR), 32'h1);
    chk("R7 five writes", wr_count - c0, 5);
    repeat (5) @(negedge clk);
    reg_read(3'd3, d); chk("R6 flag sticky", {32'd0, d}, 64'h1);
    reg_write(3'd0, cw(1, 1, 1, 1, 1, 0, 3));
    reg_read(3'd3, d); chk("R6 flag cleared", {32'd0, d}, 64'h0);
  endtask

  task automatic t_soft();
    logic [31:0] d;
    int c0;
    ring_restart(4);
    reg_write(3'd0, cw(1, 1, 0, 0, 0, 0, 4));
    send(8'h21, 28'd0, 8'd0, 8'd0, 16'd0);
    c0 = wr_count;
    offer(8'h22, 28'd0, 8'd0, 8'd0, 16'd0);
    reg_write(3'd0, cw(1, 1, 0, 0, 0, 1, 4));
    ev_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 no accept", {63'd0, ev_ready}, 64'd0);
    ev_valid = 1'b0;
    reg_write(3'd0, cw(1, 1, 0, 0, 0, 0, 4));
    repeat (4) @(negedge clk);
    chk("R10 aborted writes", wr_count - c0, 2);
    reg_read(3'd3, d); chk("R10 wptr zero", {32'd0, d}, 64'h0);
    reg_read(3'd0, d); chk("R10 idle", {63'd0, d[16]}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gate();
    t_layout();
    t_wrap();
    t_full();
    t_soft();
    summary();
    $finish;
  end

endmodule